// File: doc/BRIEF.md
# Root-Port Legacy Interrupt Collector

This block gathers legacy INTx assert and deassert messages that arrive from the downstream side of a PCIe root port and presents them to software through a small register window. Each incoming event carries a lane number (INTA to INTD as 0 to 3) and a level. It is held as one entry in a circular queue. Software inspects the oldest entry through two read windows, and it discards that entry by writing any value to either window.

Alongside the queue the block holds an interrupt cause register whose bits clear when written with one, an interrupt enable register, a root-port control and status word (bridge enable, queue-empty flag, sticky overflow flag) and a link status word that reflects an input pin. The single interrupt output is high while any cause bit is enabled. While the queue holds entries, the INTx cause bit cannot stay cleared. The queue keeps one slot free, so its capacity is one less than its depth. An event that arrives while the queue is full is lost and raises the overflow flag.

Top module: `rp_intx_collector`

## Requirements
- R1: After a synchronous reset the cause register, the enable register, the bridge enable and the overflow flag read 0, the queue is empty (control word 0x148 reads 0x0004_0000) and `irq` is low.
- R2: An accepted event is stored so that window 0x158 reads bit 31 = 1, bit 29 = level and bits 28:27 = lane, with every other bit 0. Window 0x15C reads 0 for every stored entry.
- R3: Entries leave in arrival order, and the queue holds at most DEPTH-1 entries (15 with the default DEPTH of 16).
- R4: An event that arrives while DEPTH-1 entries are held is dropped and sets bit 19 of 0x148. That bit stays set until reset.
- R5: Reading 0x158 or 0x15C returns the oldest entry without removing it. Both read 0 while the queue is empty.
- R6: A write of any value to 0x158 or 0x15C removes exactly one entry. On an empty queue such a write changes nothing.
- R7: Bit 16 (INTx) of the cause register 0x138 is 1 whenever the queue holds an entry. Writing 1 to bit 16 or bit 17 of 0x138 clears that bit unless the queue is non-empty. The INTx bit stays set after the queue drains, until software clears it.
- R8: `irq` is the OR of (cause AND enable) over bits 16 and 17. The enable register at 0x13C reads back the full 32-bit value written.
- R9: Bit 18 of 0x148 reads 1 when the queue is empty and 0 when it holds entries.
- R10: Bit 0 of 0x148 is read/write and drives `bridge_en`. Bit 11 of 0x144 reads the `link_up` input. Other bits of both words read 0.
- R11: When an event and a removal occur in the same cycle, both take effect. The full test uses the queue state from before the removal, so an event that meets a full queue is dropped even if an entry leaves in that cycle.
- R12: Reads of any other offset return 0, and writes to any other offset change no state. `bus_rdata` is 0 when `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | An INTx event is presented this cycle |
| evt_lane | input | 2 | Lane number of the event |
| evt_level | input | 1 | 1 for assert, 0 for deassert |
| link_up | input | 1 | Link status from the physical layer |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current state |
| bridge_en | output | 1 | Bridge enable bit |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
The bench drives the queue past its capacity and checks that exactly DEPTH-1 entries survive and that the overflow flag sets and holds. A design whose full test was off by one would lose or overrun a slot. It applies an event and a removal in the same cycle on a full queue, where a design that tested fullness after the removal would keep an event that must be lost. It also pops an empty queue and expects the pointers to stay put, and it clears the INTx cause while entries remain and after they drain, which exposes a cause bit that fails to stick or one that clears itself on a pop. Every cycle is compared with a queue-based model, so an entry encoding with the wrong bits or a read that pops would show up at once.

// File: rtl/rp_irq_pkg.sv
package rp_irq_pkg;

    localparam int unsigned LANE_W = 2;

    localparam logic [11:0] OFS_CAUSE  = 12'h138;
    localparam logic [11:0] OFS_ENABLE = 12'h13C;
    localparam logic [11:0] OFS_LINK   = 12'h144;
    localparam logic [11:0] OFS_RPCTL  = 12'h148;
    localparam logic [11:0] OFS_HEAD0  = 12'h158;
    localparam logic [11:0] OFS_HEAD1  = 12'h15C;

    localparam int unsigned B_INTX  = 16;
    localparam int unsigned B_MSI   = 17;
    localparam int unsigned B_LINK  = 11;
    localparam int unsigned B_BREN  = 0;
    localparam int unsigned B_EMPTY = 18;
    localparam int unsigned B_OVF   = 19;
    localparam int unsigned B_LANE  = 27;
    localparam int unsigned B_LEVEL = 29;
    localparam int unsigned B_VALID = 31;

    typedef struct packed {
        logic [LANE_W-1:0] lane;
        logic              level;
    } intx_evt_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAUSE,
        SEL_ENABLE,
        SEL_LINK,
        SEL_RPCTL,
        SEL_HEAD0,
        SEL_HEAD1
    } reg_sel_t;

    function automatic reg_sel_t map_offset(input logic [11:0] ofs);
        case (ofs)
            OFS_CAUSE:  return SEL_CAUSE;
            OFS_ENABLE: return SEL_ENABLE;
            OFS_LINK:   return SEL_LINK;
            OFS_RPCTL:  return SEL_RPCTL;
            OFS_HEAD0:  return SEL_HEAD0;
            OFS_HEAD1:  return SEL_HEAD1;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic logic [31:0] entry_word(input intx_evt_t e);
        logic [31:0] w;
        w = '0;
        w[B_VALID]             = 1'b1;
        w[B_LEVEL]             = e.level;
        w[B_LANE +: LANE_W]    = e.lane;
        return w;
    endfunction

endpackage

// File: rtl/rp_irq_fifo.sv
module rp_irq_fifo
    import rp_irq_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push_i,
    input  intx_evt_t push_evt_i,
    input  logic      pop_i,
    output intx_evt_t head_o,
    output logic      empty_o,
    output logic      drop_o,
    output logic      nonempty_next_o
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    intx_evt_t     slots [DEPTH];
    logic [PW-1:0] wp_q, rp_q, wp_d, rp_d, wp_inc;
    logic          full, accept, take;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign wp_inc  = step(wp_q);
    assign empty_o = (wp_q == rp_q);
    assign full    = (wp_inc == rp_q);
    assign accept  = push_i && !full;
    assign take    = pop_i && !empty_o;
    assign drop_o  = push_i && full;

    assign wp_d = accept ? wp_inc : wp_q;
    assign rp_d = take ? step(rp_q) : rp_q;
    assign nonempty_next_o = (wp_d != rp_d);
    assign head_o = slots[rp_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            wp_q <= wp_d;
            rp_q <= rp_d;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) slots[wp_q] <= push_evt_i;
    end

    // R4
    drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (push_i && full) |=> (wp_q == $past(wp_q)));

    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_i && empty_o) |=> (rp_q == $past(rp_q)));

    // R11
    push_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i && !full && !empty_o) |=> !empty_o);

endmodule

// File: rtl/rp_irq_regs.sv
module rp_irq_regs
    import rp_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        link_up,
    input  intx_evt_t   head_i,
    input  logic        empty_i,
    input  logic        drop_i,
    input  logic        nonempty_next_i,
    output logic        pop_o,
    output logic [31:0] bus_rdata,
    output logic        bridge_en,
    output logic        irq
);
    reg_sel_t    sel;
    logic [1:0]  cause_q, cause_d, cause_clr;   // {msi, intx}
    logic [31:0] enable_q;
    logic        ovf_q, bren_q;
    logic [31:0] head_word;

    assign sel   = map_offset(bus_addr);
    assign pop_o = bus_wr && (sel == SEL_HEAD0 || sel == SEL_HEAD1);

    assign cause_clr = (bus_wr && sel == SEL_CAUSE) ?
                       {bus_wdata[B_MSI], bus_wdata[B_INTX]} : 2'b00;
    assign cause_d   = (cause_q & ~cause_clr) | {1'b0, nonempty_next_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q  <= '0;
            enable_q <= '0;
            ovf_q    <= 1'b0;
            bren_q   <= 1'b0;
        end else begin
            cause_q <= cause_d;
            if (drop_i) ovf_q <= 1'b1;
            if (bus_wr && sel == SEL_ENABLE) enable_q <= bus_wdata;
            if (bus_wr && sel == SEL_RPCTL)  bren_q   <= bus_wdata[B_BREN];
        end
    end

    assign irq       = |(cause_q & {enable_q[B_MSI], enable_q[B_INTX]});
    assign bridge_en = bren_q;
    assign head_word = empty_i ? 32'h0 : entry_word(head_i);

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                SEL_CAUSE: begin
                    bus_rdata[B_INTX] = cause_q[0];
                    bus_rdata[B_MSI]  = cause_q[1];
                end
                SEL_ENABLE: bus_rdata = enable_q;
                SEL_LINK:   bus_rdata[B_LINK] = link_up;
                SEL_RPCTL: begin
                    bus_rdata[B_BREN]  = bren_q;
                    bus_rdata[B_EMPTY] = empty_i;
                    bus_rdata[B_OVF]   = ovf_q;
                end
                SEL_HEAD0: bus_rdata = head_word;
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R7
    intx_forced_chk: assert property (@(posedge clk) disable iff (rst)
        !empty_i |-> cause_q[0]);

    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);

    // R10
    bren_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_RPCTL) |=> (bridge_en == $past(bus_wdata[B_BREN])));

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_ENABLE && bus_wdata[B_INTX:B_MSI-1] == 2'b00
         && bus_wdata[B_MSI] == 1'b0) |=> !irq);

endmodule

// File: rtl/rp_intx_collector.sv
module rp_intx_collector
    import rp_irq_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        evt_valid,
    input  logic [1:0]  evt_lane,
    input  logic        evt_level,
    input  logic        link_up,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bridge_en,
    output logic        irq
);
    intx_evt_t evt, head;
    logic      empty, drop, ne_next, pop;

    assign evt.lane  = evt_lane;
    assign evt.level = evt_level;

    rp_irq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk             (clk),
        .rst             (rst),
        .push_i          (evt_valid),
        .push_evt_i      (evt),
        .pop_i           (pop),
        .head_o          (head),
        .empty_o         (empty),
        .drop_o          (drop),
        .nonempty_next_o (ne_next)
    );

    rp_irq_regs u_regs (
        .clk             (clk),
        .rst             (rst),
        .bus_wr          (bus_wr),
        .bus_rd          (bus_rd),
        .bus_addr        (bus_addr),
        .bus_wdata       (bus_wdata),
        .link_up         (link_up),
        .head_i          (head),
        .empty_i         (empty),
        .drop_i          (drop),
        .nonempty_next_i (ne_next),
        .pop_o           (pop),
        .bus_rdata       (bus_rdata),
        .bridge_en       (bridge_en),
        .irq             (irq)
    );

endmodule

// File: tb/rp_intx_collector_test.sv
`timescale 1ns/1ps
module rp_intx_collector_test;
    localparam int DEPTH = 16;

    logic        clk = 0, rst = 1;
    logic        evt_valid = 0, evt_level = 0, link_up = 0;
    logic [1:0]  evt_lane = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [11:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        bridge_en, irq;

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model state
    int unsigned q[$];
    bit          m_intx, m_ovf, m_bren;
    logic [31:0] m_en;
    logic [31:0] last_rd;

    always #2 clk = ~clk;

    rp_intx_collector #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_lane(evt_lane),
        .evt_level(evt_level), .link_up(link_up), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bridge_en(bridge_en), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic string tag_of(input logic [11:0] a);
        case (a)
            12'h138: return "R7";
            12'h13C: return "R8";
            12'h144: return "R10";
            12'h148: return "R9";
            12'h158, 12'h15C: return "R3";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        logic [31:0] v = 0;
        case (a)
            12'h138: v[16] = m_intx;
            12'h13C: v = m_en;
            12'h144: v[11] = link_up;
            12'h148: begin v[0] = m_bren; v[18] = (q.size() == 0); v[19] = m_ovf; end
            12'h158: v = (q.size() == 0) ? 0 : q[0];
            default: v = 0;
        endcase
        return v;
    endfunction

    // one clock: drive after negedge, compare before posedge, advance model at posedge
    task automatic cyc(input bit ev, input int lane, input bit lvl,
                       input bit wr, input bit rd, input logic [11:0] a, input logic [31:0] wd);
        bit empty0, full0, popit;
        evt_valid = ev; evt_lane = lane[1:0]; evt_level = lvl;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        #1;
        last_rd = bus_rdata;
        if (!rst) begin
            chk(rd ? tag_of(a) : "R12", bus_rdata, rd ? model_read(a) : 32'h0);
            chk("R8", {31'h0, irq}, {31'h0, (m_intx & m_en[16])});
            chk("R10", {31'h0, bridge_en}, {31'h0, m_bren});
        end
        @(posedge clk);
        if (rst) begin
            q.delete(); m_intx = 0; m_ovf = 0; m_bren = 0; m_en = 0;
        end else begin
            empty0 = (q.size() == 0);
            full0  = (q.size() == DEPTH - 1);
            popit  = wr && (a == 12'h158 || a == 12'h15C) && !empty0;
            if (ev && full0) m_ovf = 1;
            if (popit) void'(q.pop_front());
            if (ev && !full0) q.push_back(32'h8000_0000 | (int'(lvl) << 29) | (lane << 27));
            if (wr && a == 12'h138 && wd[16]) m_intx = 0;
            if (q.size() > 0) m_intx = 1;
            if (wr && a == 12'h13C) m_en = wd;
            if (wr && a == 12'h148) m_bren = wd[0];
        end
        @(negedge clk);
        evt_valid = 0; bus_wr = 0; bus_rd = 0;
    endtask

    task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0); endtask
    task automatic rd(input logic [11:0] a); cyc(0, 0, 0, 0, 1, a, 0); endtask
    task automatic wr(input logic [11:0] a, input logic [31:0] d); cyc(0, 0, 0, 1, 0, a, d); endtask
    task automatic ev(input int lane, input bit lvl); cyc(1, lane, lvl, 0, 0, 0, 0); endtask

    task automatic do_reset();
        rst = 1; idle(); idle(); rst = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        rd(12'h148); chk("R1", last_rd, 32'h0004_0000);
        rd(12'h138); chk("R1", last_rd, 32'h0);
        rd(12'h13C); chk("R1", last_rd, 32'h0);
        chk("R1", {31'h0, irq}, 32'h0);

        // R2 encoding, R5 non-destructive read
        ev(2, 1);
        rd(12'h158); chk("R2", last_rd, 32'hB000_0000);
        rd(12'h15C); chk("R2", last_rd, 32'h0);
        rd(12'h158); chk("R5", last_rd, 32'hB000_0000);
        rd(12'h148); chk("R9", last_rd, 32'h0);
        rd(12'h138); chk("R7", last_rd, 32'h0001_0000);

        // R8 enable gates irq
        wr(12'h13C, 32'hA5A5_0000 | 32'h0001_0000);
        rd(12'h13C); chk("R8", last_rd, 32'hA5A5_0000 | 32'h0001_0000);
        idle(); chk("R8", {31'h0, irq}, 32'h1);

        // R7 clear while non-empty has no effect; stays after drain
        wr(12'h138, 32'h0003_0000);
        rd(12'h138); chk("R7", last_rd, 32'h0001_0000);
        wr(12'h15C, 32'h1234);
        rd(12'h158); chk("R5", last_rd, 32'h0);
        rd(12'h138); chk("R7", last_rd, 32'h0001_0000);
        wr(12'h138, 32'h0001_0000);
        rd(12'h138); chk("R7", last_rd, 32'h0);
        chk("R8", {31'h0, irq}, 32'h0);

        // R6 pop on empty does nothing
        wr(12'h158, 32'hFFFF_FFFF);
        ev(1, 0);
        rd(12'h158); chk("R6", last_rd, 32'h8800_0000);
        wr(12'h158, 0);

        // R3/R4 fill past capacity
        for (int i = 0; i < 20; i++) ev(i % 4, i[0]);
        rd(12'h148); chk("R4", last_rd, 32'h0008_0000);
        // R11 event plus pop on a full queue: event dropped
        cyc(1, 3, 1, 1, 0, 12'h158, 0);
        for (int i = 1; i < DEPTH - 1; i++) begin
            rd(12'h158);
            chk("R3", last_rd, 32'h8000_0000 | ((i % 2) << 29) | ((i % 4) << 27));
            wr(12'h15C, 0);
        end
        rd(12'h148); chk("R11", last_rd, 32'h000C_0000);

        // R11 push and pop together on one entry
        ev(0, 1);
        cyc(1, 3, 0, 1, 0, 12'h15C, 0);
        rd(12'h158); chk("R11", last_rd, 32'h9800_0000);
        wr(12'h158, 0);

        // R10 bridge enable and link status
        wr(12'h148, 32'hFFFF_FFFF); idle(); chk("R10", {31'h0, bridge_en}, 32'h1);
        rd(12'h148); chk("R10", last_rd, 32'h000C_0001);
        wr(12'h148, 0); idle(); chk("R10", {31'h0, bridge_en}, 32'h0);
        link_up = 1; rd(12'h144); chk("R10", last_rd, 32'h0000_0800);
        link_up = 0; rd(12'h144); chk("R10", last_rd, 32'h0);

        // R12 unmapped offsets
        wr(12'h100, 32'hFFFF_FFFF);
        rd(12'h100); chk("R12", last_rd, 32'h0);
        rd(12'h13C); chk("R12", last_rd, 32'hA5A5_0000 | 32'h0001_0000);

        // R4 overflow sticky until reset; R1 reset clears it
        rd(12'h148); chk("R4", last_rd[19], 1'b1);
        do_reset();
        rd(12'h148); chk("R1", last_rd, 32'h0004_0000);
        repeat (4) idle();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule